// File: doc/BRIEF.md
# Multi-Mode Serial Transmit Engine

This block is the transmit half of a serial port that one 8-bit control byte configures. It can frame a word as an asynchronous character, send the same character with an accompanying serial clock, or act as a byte-wide SPI-style master shifter. The mode field decides how the lower bits of the control byte are read. In the character modes they set the data length and parity. In the shifter mode they set the bit order and the clock phase.

The host writes the control byte once, presents a data word and pulses a load strobe. An external divider supplies a single-cycle baud tick. Every tick advances the line by one bit in asynchronous mode, or by one clock half-period in the clocked modes. The `busy` output stays high while a frame is in flight. A one-cycle `done` pulse marks the end of the frame.

Top module: `sertx_engine`

## Requirements
- R1: After reset, `ser_out` is 1, `ser_clk`, `busy` and `done` are 0, and the control byte is 00h, so the first frame is an asynchronous 5-bit frame without parity.
- R2: Control bits 7:6 select the mode: 00 asynchronous, 01 clocked character, 11 byte shifter. The reserved code 10 behaves exactly as 00.
- R3: An asynchronous frame sends a 0 start bit, then the data bits LSB first, then the parity bit if enabled, then one 1 stop bit. Each bit lasts from one baud tick to the next, and `ser_out` is 1 whenever no frame is active.
- R4: Outside shifter mode, control bits 3:1 set the number of data bits: 000, 001, 010 and 011 give 5, 6, 7 and 8, 111 gives 9, and 100 to 110 give 5. The bits sent are `tx_data[n-1:0]`.
- R5: Control bits 5:4 set the parity. 10 adds a bit that makes the count of ones in data plus parity even. 11 makes that count odd. 00 and 01 add no bit. Shifter mode never adds parity.
- R6: Clocked character mode sends the bit sequence of R3 on `ser_out` and toggles `ser_clk` once per baud tick. Each bit is driven at the leading clock edge and held through the trailing edge.
- R7: Shifter mode sends exactly `tx_data[7:0]` with no start, stop or parity bit. Control bit 2 = 1 sends the MSB first and 0 sends the LSB first.
- R8: In shifter mode with control bit 1 = 0, the first bit is on `ser_out` from the cycle after the load, before the first clock edge, and each later bit changes at a trailing edge. With bit 1 = 1, bits change at leading edges as in R6.
- R9: In the clocked modes `ser_clk` idles at the level of control bit 0, and the leading edge moves it away from that level. In asynchronous mode `ser_clk` stays 0.
- R10: `busy` rises in the cycle after an accepted load. On the tick that ends the last bit, `busy` falls, `done` is high for exactly that one cycle, and `ser_out` returns to 1.
- R11: A load while `busy` is high is ignored. A control write during a frame does not change that frame. It applies from the next frame on.
- R12: During a frame, `ser_out` and `ser_clk` change only in the cycle after a baud tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte value |
| tx_data | input | DATA_W | Word to transmit |
| tx_load | input | 1 | Start a frame with `tx_data` |
| baud_tick | input | 1 | One-cycle bit/half-bit timing pulse |
| ser_out | output | 1 | Serial data line |
| ser_clk | output | 1 | Serial clock for the clocked modes |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest situation to reach from the ports is a load or a control write that arrives in the middle of a frame. The engine must keep sending the latched frame and then stay idle. To get there, the stimulus raises `tx_load` with different data and writes a conflicting shifter-mode control byte after the second bit has started. It then checks every remaining bit and confirms that `busy` stays low after `done`. The random part of the stimulus draws the whole control byte, so reserved codes and mode-dependent field meanings occur together. Between ticks it inserts random idle gaps to show that the lines hold still.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int CTRL_W  = 8;
  localparam int SPI_W   = 8;
  localparam int DBITS_W = 4;

  typedef enum logic [1:0] {
    MODE_UART = 2'd0,
    MODE_SYNC = 2'd1,
    MODE_SPI  = 2'd2
  } mode_e;

  typedef struct packed {
    mode_e              mode;
    logic               par_en;
    logic               par_odd;
    logic [DBITS_W-1:0] dbits;
    logic               msb_first;
    logic               cpha;
    logic               cpol;
  } cfg_t;

  function automatic cfg_t decode_ctrl(input logic [CTRL_W-1:0] r);
    cfg_t c;
    case (r[7:6])
      2'b01:   c.mode = MODE_SYNC;
      2'b11:   c.mode = MODE_SPI;
      default: c.mode = MODE_UART;
    endcase
    c.par_en  = r[5];
    c.par_odd = r[5] & r[4];
    case (r[3:1])
      3'b000:  c.dbits = 4'd5;
      3'b001:  c.dbits = 4'd6;
      3'b010:  c.dbits = 4'd7;
      3'b011:  c.dbits = 4'd8;
      3'b111:  c.dbits = 4'd9;
      default: c.dbits = 4'd5;
    endcase
    c.msb_first = r[2];
    c.cpha      = r[1];
    c.cpol      = r[0];
    if (c.mode == MODE_SPI) begin
      c.par_en  = 1'b0;
      c.par_odd = 1'b0;
      c.dbits   = DBITS_W'(SPI_W);
    end
    return c;
  endfunction

endpackage

// File: rtl/sertx_cfg.sv
module sertx_cfg
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output cfg_t              cfg
);

  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst)     ctrl_q <= '0;
    else if (we) ctrl_q <= wdata;
  end

  assign cfg = decode_ctrl(ctrl_q);

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int FRAME_W = DATA_W + 3,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  cfg_t               cfg,
  input  logic [DATA_W-1:0]  data,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   len
);

  logic             par;
  logic [CNT_W-1:0] pos;

  always_comb begin
    frame = '1;
    len   = '0;
    par   = 1'b0;
    pos   = '0;
    if (cfg.mode == MODE_SPI) begin
      for (int i = 0; i < SPI_W; i++) begin
        frame[i] = cfg.msb_first ? data[SPI_W-1-i] : data[i];
      end
      len = CNT_W'(SPI_W);
    end else begin
      frame[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
        if (i < int'(cfg.dbits)) begin
          frame[i+1] = data[i];
          par        = par ^ data[i];
        end
      end
      pos = CNT_W'(cfg.dbits) + CNT_W'(1);
      if (cfg.par_en) frame[pos] = par ^ cfg.par_odd;
      len = CNT_W'(cfg.dbits) + CNT_W'(2) + CNT_W'(cfg.par_en);
    end
  end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int FRAME_W = 12,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   len_in,
  input  logic               clocked_in,
  input  logic               lead_in,
  input  logic               cpol_in,
  input  logic               idle_clk,
  input  logic               baud_tick,
  output logic               ser_out,
  output logic               ser_clk,
  output logic               busy,
  output logic               done
);

  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   len_q;
  logic [CNT_W-1:0]   idx_q;
  logic               half_q;
  logic               clocked_q;
  logic               lead_q;
  logic               cpol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_out   <= 1'b1;
      ser_clk   <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      frame_q   <= '1;
      len_q     <= '0;
      idx_q     <= '0;
      half_q    <= 1'b0;
      clocked_q <= 1'b0;
      lead_q    <= 1'b0;
      cpol_q    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        ser_clk <= idle_clk;
        if (start) begin
          busy      <= 1'b1;
          frame_q   <= frame_in;
          len_q     <= len_in;
          clocked_q <= clocked_in;
          lead_q    <= lead_in;
          cpol_q    <= cpol_in;
          idx_q     <= '0;
          half_q    <= 1'b0;
          ser_out   <= lead_in ? 1'b1 : frame_in[0];
        end
      end else if (baud_tick) begin
        if (clocked_q && !half_q) begin
          half_q  <= 1'b1;
          ser_clk <= ~cpol_q;
          if (lead_q) ser_out <= frame_q[idx_q];
        end else begin
          half_q <= 1'b0;
          if (clocked_q) ser_clk <= cpol_q;
          if (idx_q == len_q - CNT_W'(1)) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            ser_out <= 1'b1;
          end else begin
            idx_q <= idx_q + CNT_W'(1);
            if (!lead_q) ser_out <= frame_q[idx_q + CNT_W'(1)];
          end
        end
      end
    end
  end

endmodule

// File: rtl/sertx_engine.sv
module sertx_engine
  import sertx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_load,
  input  logic              baud_tick,
  output logic              ser_out,
  output logic              ser_clk,
  output logic              busy,
  output logic              done
);

  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  cfg_t               cfg;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   len;
  logic               clocked;
  logic               lead;

  sertx_cfg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  sertx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
    .cfg   (cfg),
    .data  (tx_data),
    .frame (frame),
    .len   (len)
  );

  assign clocked = (cfg.mode != MODE_UART);
  assign lead    = (cfg.mode == MODE_SYNC) || ((cfg.mode == MODE_SPI) && cfg.cpha);

  sertx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .start      (tx_load && !busy),
    .frame_in   (frame),
    .len_in     (len),
    .clocked_in (clocked),
    .lead_in    (lead),
    .cpol_in    (cfg.cpol),
    .idle_clk   (clocked && cfg.cpol),
    .baud_tick  (baud_tick),
    .ser_out    (ser_out),
    .ser_clk    (ser_clk),
    .busy       (busy),
    .done       (done)
  );

endmodule

// File: rtl/sertx_engine_chk.sv
module sertx_engine_chk #(
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [7:0]        cfg_wdata,
  input logic [DATA_W-1:0] tx_data,
  input logic              tx_load,
  input logic              baud_tick,
  input logic              ser_out,
  input logic              ser_clk,
  input logic              busy,
  input logic              done
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                                         // R10

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));                                        // R10

  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);                                                   // R10

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ser_out);                                                      // R3

  AST_LOAD_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
    (tx_load && !busy) |=> busy);                                            // R11

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(baud_tick)) |-> ($stable(ser_out) && $stable(ser_clk))); // R12

endmodule

bind sertx_engine sertx_engine_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sertx_engine_test.sv
module sertx_engine_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [8:0] tx_data = '0;
  logic       tx_load = 1'b0;
  logic       baud_tick = 1'b0;
  logic       ser_out, ser_clk, busy, done;

  int n_run  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #10 clk = ~clk;

  sertx_engine #(.DATA_W(9)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tx_data(tx_data), .tx_load(tx_load), .baud_tick(baud_tick),
    .ser_out(ser_out), .ser_clk(ser_clk), .busy(busy), .done(done)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic ref_frame(input logic [7:0] c, input logic [8:0] d,
                           output logic [11:0] f, output int n,
                           output bit clocked, output bit lead, output bit cpol);
    int  db;
    bit  p;
    f = '1;
    cpol = c[0];
    clocked = (c[7:6] == 2'b01) || (c[7:6] == 2'b11);
    if (c[7:6] == 2'b11) begin
      lead = c[1];
      n = 8;
      for (int i = 0; i < 8; i++) f[i] = c[2] ? d[7-i] : d[i];
    end else begin
      lead = (c[7:6] == 2'b01);
      if (c[3:1] <= 3'd3) db = 5 + int'(c[3:1]);
      else if (c[3:1] == 3'd7) db = 9;
      else db = 5;
      f[0] = 1'b0;
      p = 1'b0;
      for (int i = 0; i < db; i++) begin
        f[1+i] = d[i];
        p = p ^ d[i];
      end
      n = db + 2;
      if (c[5]) begin
        f[1+db] = p ^ c[4];
        n = n + 1;
      end
    end
  endtask

  task automatic tick(input string rq);
    logic po, pc;
    po = ser_out;
    pc = ser_clk;
    repeat ($urandom_range(0, 2)) begin
      @(negedge clk);
      chk("R12 data hold", ser_out, po);
      chk("R12 clock hold", ser_clk, pc);
    end
    baud_tick = 1'b1;
    @(negedge clk);
    baud_tick = 1'b0;
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] c, input logic [8:0] d, input bit poke);
    logic [11:0] f;
    int    n;
    bit    clocked, lead, cpol, idle;
    string rq;
    ref_frame(c, d, f, n, clocked, lead, cpol);
    idle = clocked & cpol;
    rq = (c[7:6] == 2'b11) ? "R7" : (c[7:6] == 2'b01) ? "R6" : "R3";
    @(negedge clk);
    chk("R3 idle line", ser_out, 1);
    chk("R9 idle clock", ser_clk, idle);
    chk("R10 idle busy", busy, 0);
    tx_data = d;
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    chk("R10 busy rise", busy, 1);
    chk("R8 first bit", ser_out, lead ? 1 : f[0]);
    chk("R9 clock before edge", ser_clk, idle);
    for (int i = 0; i < n; i++) begin
      if (poke && i == 1) begin
        @(negedge clk);
        tx_load = 1'b1;
        tx_data = ~d;
        cfg_we = 1'b1;
        cfg_wdata = 8'hC7;
        @(negedge clk);
        tx_load = 1'b0;
        cfg_we = 1'b0;
      end
      if (clocked) begin
        tick(rq);
        chk("R9 leading edge", ser_clk, !cpol);
        if (lead) chk(rq, ser_out, f[i]);
      end
      tick(rq);
      if (clocked) chk("R9 trailing edge", ser_clk, cpol);
      if (i == n - 1) begin
        chk("R10 done pulse", done, 1);
        chk("R10 busy fall", busy, 0);
        chk("R10 line back high", ser_out, 1);
      end else begin
        chk(rq, ser_out, lead ? f[i] : f[i+1]);
        chk("R10 busy held", busy, 1);
      end
    end
    @(negedge clk);
    chk("R10 done cleared", done, 0);
    chk("R11 no restart", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 ser_out", ser_out, 1);
    chk("R1 ser_clk", ser_clk, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    send(8'h00, 9'h0B5, 0);             // R1 default 5-bit UART frame
    write_cfg(8'h06); send(8'h06, 9'h0A5, 0);  // R3 R4 8 bits
    write_cfg(8'h2E); send(8'h2E, 9'h1C3, 0);  // R4 R5 9 bits even
    write_cfg(8'h3E); send(8'h3E, 9'h1C3, 0);  // R5 odd
    write_cfg(8'h14); send(8'h14, 9'h055, 0);  // R5 reserved parity
    write_cfg(8'h0A); send(8'h0A, 9'h1FF, 0);  // R4 reserved size
    write_cfg(8'h86); send(8'h86, 9'h03C, 0);  // R2 reserved mode
    write_cfg(8'h46); send(8'h46, 9'h0C9, 0);  // R6
    write_cfg(8'h67); send(8'h67, 9'h0F1, 0);  // R6 R9
    write_cfg(8'hC4); send(8'hC4, 9'h1A6, 0);  // R7 R8 msb first
    write_cfg(8'hC0); send(8'hC0, 9'h1A6, 0);  // R7 lsb first
    write_cfg(8'hC2); send(8'hC2, 9'h05A, 0);  // R8 phase 1
    write_cfg(8'hF7); send(8'hF7, 9'h133, 0);  // R5 R7 R9
    write_cfg(8'h06); send(8'h06, 9'h0E4, 1);  // R11 mid-frame load/write
    for (int k = 0; k < 40; k++) begin
      logic [7:0] c;
      logic [8:0] d;
      c = 8'($urandom);
      d = 9'($urandom);
      write_cfg(c);
      send(c, d, 0);
    end
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule